// File: doc/BRIEF.md
# Dibit Differential Phase Encoder

This block sits between a scrambler and a four-phase modulator. The host writes each scrambled byte into a one-byte holding register. When the symbol shifter runs out of symbols, the byte moves from the holding register into the shifter. On every symbol strobe the shifter sends out one two-bit symbol, starting with the lowest pair of the byte. Each symbol becomes a phase increment counted in quarter turns, and the block adds it to a running absolute phase index. The modulator reads the increment and the absolute phase for each strobe, and a one-cycle valid flag marks each new symbol.

The two buffers let the host write the next byte while the current byte is still going out. It has four symbol periods to do so. If no byte is ready when one is needed, the block sends the no-change symbol and sets a sticky underrun flag. If the host writes while the holding register is still full, the write is dropped and a sticky overrun flag is set.

Top module: `dibit_phase_encoder`

## Requirements
- R1: A synchronous reset, with `rst` high at a rising clock edge, clears the following: `phase_abs`, `phase_inc`, `sym_valid`, `underrun` and `overrun` all read 0, and both the holding register and the shifter are empty.
- R2: A byte is sent as four symbols on four successive strobes. The order is bits [1:0], then [3:2], then [5:4], then [7:6]. Each symbol value is {upper bit, lower bit} of its pair.
- R3: Each symbol is mapped to `phase_inc` in quarter turns: 00 gives 1, 01 gives 0, 11 gives 3 and 10 gives 2.
- R4: On each strobe, `phase_abs` becomes (previous `phase_abs` + new `phase_inc`) mod 4. Without a strobe, `phase_abs` and `phase_inc` hold their values.
- R5: `sym_valid` is high for exactly the one cycle after each rising edge at which `sym_stb` was sampled high. `phase_inc` and `phase_abs` change at that same edge.
- R6: A byte written into the holding register while the shifter still holds symbols is sent right after the last symbol of the current byte, with no gap and no underrun. The write only has to land before the strobe that needs the byte.
- R7: If a strobe needs a new byte and the holding register is empty, the symbol 01 is sent (`phase_inc` 0) and `underrun` is set. `underrun` stays set until reset. The next byte written is sent from the next strobe on.
- R8: A write (`wr_en` high) while the holding register is full at the start of the cycle is dropped, and that byte is never sent. This holds even if the same strobe moves the held byte into the shifter. The dropped write sets `overrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Scrambled byte to send |
| sym_stb | input | 1 | Symbol strobe, one symbol per high cycle |
| phase_inc | output | 2 | Phase change of the last symbol, in quarter turns |
| phase_abs | output | 2 | Running absolute phase index, mod 4 |
| sym_valid | output | 1 | High for one cycle after each symbol strobe |
| underrun | output | 1 | Sticky: a byte was needed and none was held |
| overrun | output | 1 | Sticky: a write arrived while the holding register was full |

## Verification
Every result is registered once. The phase outputs and `sym_valid` reflect a strobe one rising edge after it was sampled. `underrun` rises at that same edge, and `overrun` rises one edge after the dropped write. The bench drives its inputs at the falling edge and steps its reference model at the rising edge. It compares all five outputs at the next falling edge, so each result is checked in the first cycle it is due. The same-cycle write-and-take case and recovery after an underrun are run as directed sequences, with their expected symbol orders worked out by hand.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

    // Phase count in quarter turns
    typedef logic [1:0] quarter_t;

    // Symbol sent when no data is available: no phase change
    localparam logic [1:0] FILL_SYM = 2'b01;

    function automatic quarter_t sym_to_quarters(input logic [1:0] sym);
        quarter_t q;
        case (sym)
            2'b00:   q = 2'd1;
            2'b01:   q = 2'd0;
            2'b11:   q = 2'd3;
            default: q = 2'd2;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/dpe_holding.sv
module dpe_holding #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] data,
    output logic              overrun
);

    typedef struct packed {
        logic              full;
        logic [BYTE_W-1:0] data;
        logic              ovr;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        if (wr_en) begin
            if (st_q.full) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.full = 1'b1;
                st_d.data = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full    = st_q.full;
    assign data    = st_q.data;
    assign overrun = st_q.ovr;

endmodule

// File: rtl/dpe_shifter.sv
module dpe_shifter
    import dpe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_stb,
    input  logic              hold_full,
    input  logic [BYTE_W-1:0] hold_data,
    output logic              take,
    output logic [1:0]        sym,
    output logic              underrun
);

    localparam int SYMS  = BYTE_W / 2;
    localparam int CNT_W = (SYMS > 1) ? $clog2(SYMS) : 1;

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  left;
        logic              und;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        sym  = FILL_SYM;
        if (sym_stb) begin
            if (st_q.left != '0) begin
                sym       = st_q.sh[1:0];
                st_d.sh   = {2'b00, st_q.sh[BYTE_W-1:2]};
                st_d.left = st_q.left - 1'b1;
            end else if (hold_full) begin
                take      = 1'b1;
                sym       = hold_data[1:0];
                st_d.sh   = {2'b00, hold_data[BYTE_W-1:2]};
                st_d.left = CNT_W'(SYMS - 1);
            end else begin
                st_d.und  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign underrun = st_q.und;

endmodule

// File: rtl/dpe_phase.sv
module dpe_phase
    import dpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       emit,
    input  logic [1:0] sym,
    output quarter_t   phase_inc,
    output quarter_t   phase_abs,
    output logic       sym_valid
);

    typedef struct packed {
        quarter_t inc;
        quarter_t acc;
        logic     vld;
    } ph_t;

    ph_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (emit) begin
            st_d.inc = sym_to_quarters(sym);
            st_d.acc = st_q.acc + st_d.inc;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_inc = st_q.inc;
    assign phase_abs = st_q.acc;
    assign sym_valid = st_q.vld;

endmodule

// File: rtl/dibit_phase_encoder.sv
module dibit_phase_encoder #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              sym_stb,
    output logic [1:0]        phase_inc,
    output logic [1:0]        phase_abs,
    output logic              sym_valid,
    output logic              underrun,
    output logic              overrun
);

    logic              hold_full;
    logic [BYTE_W-1:0] hold_data;
    logic              take;
    logic [1:0]        cur_sym;

    dpe_holding #(.BYTE_W(BYTE_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data),
        .overrun (overrun)
    );

    dpe_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sym_stb   (sym_stb),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .sym       (cur_sym),
        .underrun  (underrun)
    );

    dpe_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .emit      (sym_stb),
        .sym       (cur_sym),
        .phase_inc (phase_inc),
        .phase_abs (phase_abs),
        .sym_valid (sym_valid)
    );

endmodule

// File: rtl/dpe_checker.sv
module dpe_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       sym_stb,
    input logic       hold_full,
    input logic [1:0] phase_inc,
    input logic [1:0] phase_abs,
    input logic       sym_valid,
    input logic       underrun,
    input logic       overrun
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (phase_abs == 2'd0 && phase_inc == 2'd0 && !sym_valid && !underrun && !overrun));

    assert_abs_accum_R4: assert property (@(posedge clk) disable iff (rst)
        sym_stb |=> phase_abs == 2'($past(phase_abs) + phase_inc));

    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !sym_stb |=> ($stable(phase_abs) && $stable(phase_inc)));

    assert_valid_on_stb_R5: assert property (@(posedge clk) disable iff (rst)
        sym_stb |=> sym_valid);

    assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !sym_stb |=> !sym_valid);

    assert_underrun_fill_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> (sym_valid && phase_inc == 2'd0));

    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    assert_full_write_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hold_full) |=> overrun);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

bind dibit_phase_encoder dpe_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .sym_stb   (sym_stb),
    .hold_full (hold_full),
    .phase_inc (phase_inc),
    .phase_abs (phase_abs),
    .sym_valid (sym_valid),
    .underrun  (underrun),
    .overrun   (overrun)
);

// File: tb/dibit_phase_encoder_test.sv
module dibit_phase_encoder_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sym_stb = 1'b0;
    logic [1:0] phase_inc;
    logic [1:0] phase_abs;
    logic       sym_valid;
    logic       underrun;
    logic       overrun;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    bit         m_hold_v;
    logic [7:0] m_hold_b;
    int         m_q[$];
    int         m_inc, m_abs;
    bit         m_vld, m_und, m_ovr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dibit_phase_encoder uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sym_stb   (sym_stb),
        .phase_inc (phase_inc),
        .phase_abs (phase_abs),
        .sym_valid (sym_valid),
        .underrun  (underrun),
        .overrun   (overrun)
    );

    function automatic int quarters(input int s);
        case (s)
            0: return 1;
            1: return 0;
            3: return 3;
            default: return 2;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hold_v = 0; m_hold_b = 0; m_q.delete();
        m_inc = 0; m_abs = 0; m_vld = 0; m_und = 0; m_ovr = 0;
    endtask

    task automatic compare(input string tag);
        chk(tag, "phase_inc", int'(phase_inc), m_inc);
        chk("R4", "phase_abs", int'(phase_abs), m_abs);
        chk("R5", "sym_valid", int'(sym_valid), int'(m_vld));
        chk("R7", "underrun", int'(underrun), int'(m_und));
        chk("R8", "overrun", int'(overrun), int'(m_ovr));
    endtask

    // one cycle: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(input bit wr, input logic [7:0] data, input bit stb, input string tag);
        bit hv0;
        int s;
        wr_en = wr; wr_data = data; sym_stb = stb;
        @(posedge clk);
        hv0 = m_hold_v;
        m_vld = 0;
        if (stb) begin
            if (m_q.size() == 0 && hv0) begin
                for (int k = 0; k < 4; k++) m_q.push_back(int'((m_hold_b >> (2*k)) & 8'h3));
                m_hold_v = 0;
            end
            if (m_q.size() > 0) begin
                s = m_q.pop_front();
            end else begin
                s = 1;
                m_und = 1;
            end
            m_inc = quarters(s);
            m_abs = (m_abs + m_inc) % 4;
            m_vld = 1;
        end
        if (wr) begin
            if (hv0) m_ovr = 1;
            else begin m_hold_v = 1; m_hold_b = data; end
        end
        @(negedge clk);
        wr_en = 0; sym_stb = 0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1; wr_en = 0; sym_stb = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        chk("R1", "phase_abs after reset", int'(phase_abs), 0);
        chk("R1", "phase_inc after reset", int'(phase_inc), 0);
        chk("R1", "sym_valid after reset", int'(sym_valid), 0);
        chk("R1", "underrun after reset", int'(underrun), 0);
        chk("R1", "overrun after reset", int'(overrun), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL R5 watchdog: actual 0 expected 1 (run finished)");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int lfsr;
        @(negedge clk);
        do_reset();

        // R1: buffers empty after reset, so the first strobe underruns (R7)
        step(0, 8'h00, 1, "R7");
        chk("R7", "fill symbol inc", int'(phase_inc), 0);
        chk("R7", "underrun set", int'(underrun), 1);
        step(0, 8'h00, 0, "R7");
        chk("R7", "underrun sticky", int'(underrun), 1);

        // R1: reset clears sticky flags
        do_reset();

        // R2 / R3: 0x1B -> symbols 11,10,01,00 -> inc 3,2,0,1
        step(1, 8'h1B, 0, "R2");
        step(0, 8'h00, 1, "R2");
        chk("R2", "first symbol bits 1:0", int'(phase_inc), 3);
        step(0, 8'h00, 0, "R2");
        step(0, 8'h00, 1, "R2");
        chk("R2", "second symbol bits 3:2", int'(phase_inc), 2);
        step(0, 8'h00, 1, "R3");
        chk("R3", "symbol 01 no change", int'(phase_inc), 0);
        step(0, 8'h00, 0, "R3");
        step(0, 8'h00, 1, "R3");
        chk("R3", "symbol 00 quarter turn", int'(phase_inc), 1);
        chk("R4", "abs after 3+2+0+1", int'(phase_abs), 2);

        // R6: back to back bytes, next written while the first is sent
        do_reset();
        step(1, 8'hE4, 0, "R6");
        step(0, 8'h00, 1, "R6");
        step(1, 8'h4E, 1, "R6");
        step(0, 8'h00, 1, "R6");
        step(0, 8'h00, 1, "R6");
        for (int k = 0; k < 4; k++) step(0, 8'h00, 1, "R6");
        chk("R6", "no underrun across bytes", int'(underrun), 0);
        chk("R6", "last symbol of 0x4E (01)", int'(phase_inc), 0);

        // R8: write while full is dropped
        do_reset();
        step(1, 8'h00, 0, "R8");
        step(1, 8'hFF, 0, "R8");
        chk("R8", "overrun set", int'(overrun), 1);
        for (int k = 0; k < 4; k++) step(0, 8'h00, 1, "R8");
        chk("R8", "kept byte 0x00 sent (inc 1)", int'(phase_inc), 1);
        step(0, 8'h00, 1, "R8");
        chk("R8", "dropped byte not sent", int'(phase_inc), 0);
        chk("R7", "underrun after kept byte", int'(underrun), 1);

        // R8: write in the same cycle the held byte is taken is still dropped
        do_reset();
        step(1, 8'hAA, 0, "R8");
        step(1, 8'h55, 1, "R8");
        chk("R8", "overrun on take cycle", int'(overrun), 1);
        chk("R8", "0xAA first symbol 10", int'(phase_inc), 2);
        for (int k = 0; k < 3; k++) step(0, 8'h00, 1, "R8");
        step(0, 8'h00, 1, "R8");
        chk("R8", "0x55 never sent", int'(phase_inc), 0);

        // R7: recovery after underrun
        do_reset();
        step(0, 8'h00, 1, "R7");
        step(1, 8'h03, 0, "R7");
        step(0, 8'h00, 1, "R7");
        chk("R7", "new byte sent after underrun", int'(phase_inc), 3);
        chk("R7", "underrun still sticky", int'(underrun), 1);

        // R4: long run with pseudo-random bytes and strobes
        do_reset();
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 3000; i++) begin
            bit w, s;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            s = (i % 2 == 0);
            w = (!m_hold_v && lfsr[3:0] != 0) || (lfsr[7:0] == 8'h5A);
            step(w, lfsr[15:8], s, "R4");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule